// File: doc/BRIEF.md
# PHY control register bank with per-bit write enables

This block is a small bank of 32-bit registers through which a bus master steers the digital controls of a storage-interface PHY. Every write carries its own bit-enable mask in the upper half-word: bit x of the lower half changes only when bit x+16 of the write word is set. Software can therefore flip a single field, such as the power-up control or the DLL enable, without first reading the register back. The mask is consumed by the write and never stored.

Seven control registers sit at byte offsets 0x00 through 0x18, four bytes apart, and a read-only status register sits at 0x20. Selected fields of the registers at 0x18 and 0x00 drive the PHY directly from their storage flops. The status register shows two completion flags from the PHY: calibration done and DLL ready. Both come from another clock domain and pass through a two-stage synchronizer before a read can see them. The bus side is a plain write port and a plain read port, each with its own strobe and byte address. Read data is registered.

Top module: `phyctl_regbank`

## Requirements
- R1: After a synchronous reset, all seven control registers, every PHY control output and `rd_data` are zero.
- R2: On a write to a control register, bit x (0..15) of that register takes bit x of `wr_data` when bit x+16 of `wr_data` is 1, and keeps its value otherwise.
- R3: Bits 31:16 of every read return 0, for every offset.
- R4: The control registers at 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 have separate storage. A write to one leaves the other six unchanged.
- R5: Register 0x18 drives the PHY fields. Bit 0 drives `pwr_on` (1 = powered up), bit 1 drives `dll_en`, and bits 6:4 drive `drv_sel` (0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm, 4 = 40 ohm). Each output takes the new value in the cycle after the write.
- R6: Register 0x00 drives further PHY fields. Bits 13:12 drive `freq_sel`, bit 11 drives `otap_en`, and bits 10:7 drive `otap_sel`. Each output takes the new value in the cycle after the write.
- R7: A read of 0x20 returns the synchronized calibration-done flag in bit 6 and the synchronized DLL-ready flag in bit 5. Every other bit is 0. A change on `cal_done_in` or `dll_ready_in` first shows in a read whose `rd_en` cycle starts two clock edges after the edge at which the change was first sampled.
- R8: Writes to 0x20, to unmapped offsets (0x1C, 0x24 and above) and to unaligned offsets change no register and no output. Reads of unmapped or unaligned offsets return 0.
- R9: `rd_data` loads the addressed value on the clock edge at which `rd_en` is high and holds it while `rd_en` is low.
- R10: When a read and a write hit the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Upper half: bit-enable mask; lower half: new bit values |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Registered read data |
| cal_done_in | input | 1 | Calibration done, asynchronous to clk |
| dll_ready_in | input | 1 | DLL ready, asynchronous to clk |
| pwr_on | output | 1 | PHY power-up control |
| dll_en | output | 1 | DLL enable |
| drv_sel | output | 3 | Drive strength select |
| freq_sel | output | 2 | DLL frequency range select |
| otap_en | output | 1 | Output tap-delay enable |
| otap_sel | output | 4 | Output tap-delay select |

## Verification
The bench builds the block with its default parameters: 8-bit byte offsets, 32-bit data, seven control registers and two synchronizer stages. An 8-bit offset reaches past 0x20, so the gap at 0x1C, the offsets above the status register and unaligned offsets can all be exercised. The synchronizer is tested by reading status on three back-to-back cycles after an input edge, which shows whether exactly two flops lie in the path.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
  localparam int unsigned STRIDE     = 4;
  localparam int unsigned PHY_REG    = 6;   // offset 0x18
  localparam int unsigned DLY_REG    = 0;   // offset 0x00
  localparam int unsigned PWR_BIT    = 0;
  localparam int unsigned DLLEN_BIT  = 1;
  localparam int unsigned DRV_LSB    = 4;
  localparam int unsigned DRV_W      = 3;
  localparam int unsigned FREQ_LSB   = 12;
  localparam int unsigned FREQ_W     = 2;
  localparam int unsigned OTEN_BIT   = 11;
  localparam int unsigned OTSEL_LSB  = 7;
  localparam int unsigned OTSEL_W    = 4;
  localparam int unsigned CAL_BIT    = 6;
  localparam int unsigned RDY_BIT    = 5;
  localparam int unsigned STAT_W     = 2;

  typedef struct packed {
    logic                 pwr_on;
    logic                 dll_en;
    logic [DRV_W-1:0]     drv;
    logic [FREQ_W-1:0]    freq;
    logic                 otap_en;
    logic [OTSEL_W-1:0]   otap_sel;
  } phy_ctl_t;
endpackage

// File: rtl/phyreg_sync.sv
module phyreg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d_in;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/phyreg_decode.sv
module phyreg_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_CTRL  = 7,
  parameter int unsigned STAT_ADDR = 32
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_CTRL-1:0] ctrl_sel,
  output logic                stat_sel
);
  import phyreg_pkg::*;

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_sel
    assign ctrl_sel[i] = (addr == ADDR_W'(i * STRIDE));
  end

  assign stat_sel = (addr == ADDR_W'(STAT_ADDR));
endmodule

// File: rtl/phyreg_cell.sv
module phyreg_cell #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [HALF_W-1:0] bits,
  input  logic [HALF_W-1:0] mask,
  output logic [HALF_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= (q & ~mask) | (bits & mask);
    end
  end
endmodule

// File: rtl/phyctl_regbank.sv
module phyctl_regbank #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_CTRL    = 7,
  parameter int unsigned STAT_ADDR   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cal_done_in,
  input  logic              dll_ready_in,
  output logic              pwr_on,
  output logic              dll_en,
  output logic [2:0]        drv_sel,
  output logic [1:0]        freq_sel,
  output logic              otap_en,
  output logic [3:0]        otap_sel
);
  import phyreg_pkg::*;

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [NUM_CTRL-1:0]             wsel, rsel;
  logic                            wstat, rstat;
  logic [NUM_CTRL-1:0][HALF_W-1:0] regs;
  logic [STAT_W-1:0]               stat_s;
  logic [DATA_W-1:0]               rd_next;
  phy_ctl_t                        ctl;

  phyreg_decode #(.ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .STAT_ADDR(STAT_ADDR)) i_wdec (
    .addr(wr_addr), .ctrl_sel(wsel), .stat_sel(wstat)
  );

  phyreg_decode #(.ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .STAT_ADDR(STAT_ADDR)) i_rdec (
    .addr(rd_addr), .ctrl_sel(rsel), .stat_sel(rstat)
  );

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    phyreg_cell #(.HALF_W(HALF_W)) i_cell (
      .clk (clk),
      .rst (rst),
      .we  (wr_en & wsel[i]),
      .bits(wr_data[HALF_W-1:0]),
      .mask(wr_data[DATA_W-1:HALF_W]),
      .q   (regs[i])
    );
  end

  phyreg_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({cal_done_in, dll_ready_in}),
    .d_out(stat_s)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (rsel[i]) rd_next = rd_next | {{(DATA_W-HALF_W){1'b0}}, regs[i]};
    end
    if (rstat) begin
      rd_next[CAL_BIT] = stat_s[1];
      rd_next[RDY_BIT] = stat_s[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
    end
  end

  assign ctl.pwr_on   = regs[PHY_REG][PWR_BIT];
  assign ctl.dll_en   = regs[PHY_REG][DLLEN_BIT];
  assign ctl.drv      = regs[PHY_REG][DRV_LSB +: DRV_W];
  assign ctl.freq     = regs[DLY_REG][FREQ_LSB +: FREQ_W];
  assign ctl.otap_en  = regs[DLY_REG][OTEN_BIT];
  assign ctl.otap_sel = regs[DLY_REG][OTSEL_LSB +: OTSEL_W];

  assign pwr_on   = ctl.pwr_on;
  assign dll_en   = ctl.dll_en;
  assign drv_sel  = ctl.drv;
  assign freq_sel = ctl.freq;
  assign otap_en  = ctl.otap_en;
  assign otap_sel = ctl.otap_sel;
endmodule

// File: rtl/phyreg_chk.sv
module phyreg_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              pwr_on,
  input logic              dll_en,
  input logic [2:0]        drv_sel,
  input logic [1:0]        freq_sel,
  input logic              otap_en,
  input logic [3:0]        otap_sel
);
  localparam int unsigned HALF_W = DATA_W / 2;

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_data == '0 && !pwr_on && !dll_en && drv_sel == '0 &&
                    freq_sel == '0 && !otap_en && otap_sel == '0));

  // R2
  masked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'('h18) && !wr_data[HALF_W]) |=> $stable(pwr_on));

  // R5
  pwr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'('h18) && wr_data[HALF_W]) |=> (pwr_on == $past(wr_data[0])));

  // R6
  otap_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'('h00) && wr_data[HALF_W+11]) |=> (otap_en == $past(wr_data[11])));

  // R8
  stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'('h20)) |=>
      ($stable(pwr_on) && $stable(dll_en) && $stable(drv_sel) &&
       $stable(freq_sel) && $stable(otap_en) && $stable(otap_sel)));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data[DATA_W-1:HALF_W] == '0));

  // R7
  stat_layout_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'('h20)) |=> (rd_data[DATA_W-1:7] == '0 && rd_data[4:0] == '0));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind phyctl_regbank phyreg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pwr_on(pwr_on),
  .dll_en(dll_en), .drv_sel(drv_sel), .freq_sel(freq_sel), .otap_en(otap_en),
  .otap_sel(otap_sel)
);

// File: tb/test_phyctl_regbank.sv
`timescale 1ns/1ps
module test_phyctl_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cal_done_in = 1'b0, dll_ready_in = 1'b0;
  logic        pwr_on, dll_en, otap_en;
  logic [2:0]  drv_sel;
  logic [1:0]  freq_sel;
  logic [3:0]  otap_sel;

  int unsigned n_vec = 0, n_bad = 0;
  bit          done = 1'b0;
  logic [15:0] m [7];
  logic [31:0] last_rd = '0;
  logic        cal_v = 1'b0, rdy_v = 1'b0;

  always #5 clk = ~clk;

  phyctl_regbank i_phyctl_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cal_done_in(cal_done_in), .dll_ready_in(dll_ready_in),
    .pwr_on(pwr_on), .dll_en(dll_en), .drv_sel(drv_sel), .freq_sel(freq_sel),
    .otap_en(otap_en), .otap_sel(otap_sel)
  );

  function automatic logic [15:0] f_merge(logic [15:0] old, logic [31:0] d);
    return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  function automatic bit f_mapped(logic [7:0] a);
    return (a[1:0] == 2'b00) && (a <= 8'h18);
  endfunction

  function automatic logic [31:0] f_read(logic [7:0] a);
    if (f_mapped(a)) return {16'h0, m[a[4:2]]};
    if (a == 8'h20)  return {25'h0, cal_v, rdy_v, 5'h0};
    return 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    check({req, " pwr_on R5"},   {31'h0, pwr_on},   {31'h0, m[6][0]});
    check({req, " dll_en R5"},   {31'h0, dll_en},   {31'h0, m[6][1]});
    check({req, " drv_sel R5"},  {29'h0, drv_sel},  {29'h0, m[6][6:4]});
    check({req, " freq_sel R6"}, {30'h0, freq_sel}, {30'h0, m[0][13:12]});
    check({req, " otap_en R6"},  {31'h0, otap_en},  {31'h0, m[0][11]});
    check({req, " otap_sel R6"}, {28'h0, otap_sel}, {28'h0, m[0][10:7]});
  endtask

  // One bus cycle: drive at negedge, edge, check at next negedge.
  task automatic op(bit w, logic [7:0] wa, logic [31:0] wd, bit r, logic [7:0] ra, string req);
    logic [31:0] exp_rd;
    wr_en = w; wr_addr = wa; wr_data = wd; rd_en = r; rd_addr = ra;
    exp_rd = r ? f_read(ra) : last_rd;   // R10: read sees pre-write value
    @(posedge clk);
    if (w && f_mapped(wa)) m[wa[4:2]] = f_merge(m[wa[4:2]], wd);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check({req, " rd_data R3 R9"}, rd_data, exp_rd);
    last_rd = exp_rd;
    check_outs(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 7; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 rd_data", rd_data, 32'h0);
    check_outs("R1");
    for (int i = 0; i < 7; i++) op(1'b0, 8'h0, 32'h0, 1'b1, 8'(i * 4), "R1 reg zero");

    // R5: field map of 0x18
    op(1'b1, 8'h18, 32'h0001_0001, 1'b0, 8'h0, "R5 power on");
    op(1'b1, 8'h18, 32'h0070_0040, 1'b0, 8'h0, "R5 drive 40 ohm");
    op(1'b1, 8'h18, 32'h0002_0002, 1'b1, 8'h18, "R5 dll enable R10");
    op(1'b0, 8'h0, 32'h0, 1'b1, 8'h18, "R5 readback");
    // R2: cleared mask keeps bits
    op(1'b1, 8'h18, 32'h0000_0000, 1'b1, 8'h18, "R2 empty mask");
    op(1'b1, 8'h18, 32'h0001_0000, 1'b0, 8'h0, "R2 power off only");
    // R6: field map of 0x00
    op(1'b1, 8'h00, 32'h3800_3a00, 1'b0, 8'h0, "R6 freq/otap");
    op(1'b1, 8'h00, 32'h0780_0200, 1'b1, 8'h00, "R6 otap_sel 4");
    // R4: other registers independent
    op(1'b1, 8'h0c, 32'hffff_a5a5, 1'b1, 8'h08, "R4 write 0x0c");
    op(1'b0, 8'h0, 32'h0, 1'b1, 8'h0c, "R4 read 0x0c");
    // R8: ignored writes and zero reads
    op(1'b1, 8'h20, 32'hffff_ffff, 1'b1, 8'h1c, "R8 status write");
    op(1'b1, 8'h1c, 32'hffff_ffff, 1'b1, 8'h24, "R8 gap write");
    op(1'b1, 8'h19, 32'hffff_ffff, 1'b1, 8'h19, "R8 unaligned");
    op(1'b1, 8'hfc, 32'hffff_ffff, 1'b1, 8'h18, "R8 high offset");

    // R7: two-stage status synchronizer, three back-to-back reads
    cal_done_in = 1'b1;
    op(1'b0, 8'h0, 32'h0, 1'b1, 8'h20, "R7 edge0 old");
    op(1'b0, 8'h0, 32'h0, 1'b1, 8'h20, "R7 edge1 old");
    cal_v = 1'b1;
    op(1'b0, 8'h0, 32'h0, 1'b1, 8'h20, "R7 edge2 new");
    dll_ready_in = 1'b1; rdy_v = 1'b1;
    idle(3);
    op(1'b0, 8'h0, 32'h0, 1'b1, 8'h20, "R7 both set");

    // Random mix
    for (int k = 0; k < 600; k++) begin
      logic [7:0]  wa, ra;
      logic [31:0] wd;
      bit          w, r;
      w  = ($urandom_range(0, 2) != 0);
      r  = ($urandom_range(0, 1) != 0);
      wa = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 9) * 4);
      ra = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 9) * 4);
      wd = $urandom;
      if (k % 100 == 50) begin
        cal_done_in = $urandom_range(0, 1) != 0; dll_ready_in = $urandom_range(0, 1) != 0;
        cal_v = cal_done_in; rdy_v = dll_ready_in;
        idle(3);
      end
      op(w, wa, wd, r, ra, "R2 R4 R8 R10 random");
    end
    for (int i = 0; i < 7; i++) op(1'b0, 8'h0, 32'h0, 1'b1, 8'(i * 4), "R4 final");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule